// File: doc/BRIEF.md
# Five-Channel Rate-Multiplied PWM Converter

This block turns five 8-bit codes into five pulse trains that, after an external RC filter, act as cheap digital-to-analog converters. A shared timebase divides the system clock into a PWM clock. It then counts PWM clocks through a 32-step base cycle and counts base cycles through an 8-cycle frame. Each channel uses the upper five bits of its code as the number of PWM clocks held high in every base cycle. The lower three bits add a single extra high clock in chosen base cycles, so the average over a frame resolves all 256 codes.

Software writes codes, a channel enable mask and a divider field through a small register port. Each channel pin carries either its pulse train or a pass-through general-purpose value, as its enable bit selects. Each channel is a two-state machine, `CH_LOW` and `CH_HIGH`. The transition `LOW->HIGH` is taken at a PWM tick whose next position lies inside the high window. The transition `HIGH->LOW` is taken at a tick whose next position lies outside it. With no tick the state is held. The code in use is copied from the register only when the frame wraps from cycle 7, step 31 back to cycle 0, step 0.

Top module: `pwm_dac_top`

## Requirements
- R1: Writes with `wr_en` high go to address 0..4 (code of channel 0..4), address 5 (enable mask, bit i for channel i, bits 7:5 read 0) or address 6 (divider, bits 1:0, bits 7:2 read 0). `rd_data` returns the addressed register combinationally.
- R2: After reset every code, the mask and the divider are 0, so every pin equals its `port_val` bit.
- R3: One PWM clock lasts 2^(div+1) system clocks, giving ratios 2, 4, 8 or 16.
- R4: A base cycle is 32 PWM clocks. A channel with code bits 7:3 equal to D is high for the first D PWM clocks of the cycle, counted from step 0.
- R5: A frame is base cycles 0..7. Code bit 0 adds one high clock in cycle 4, bit 1 in cycles 2 and 6, bit 2 in cycles 1, 3, 5 and 7. Each added clock extends that cycle's high time by exactly one PWM clock, so a frame holds 8*D + (bits 2:0) high PWM clocks.
- R6: A pin carries the channel's pulse train when its enable bit is 1, and its `port_val` bit when the enable bit is 0.
- R7: A code written mid-frame has no effect on the output until the next frame starts.
- R8: Code 00h gives a constant low pulse train.
- R9: A write to address 7 changes no register and no output.
- R10: All channels share one timebase, so channels holding equal codes give identical pulse trains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| port_val | input | 5 | General-purpose values passed to pins whose enable is 0 |
| pin_out | output | 5 | Pin values |

## Verification
Register readback and the pass-through path are combinational, so their results are sampled in the same cycle the address or `port_val` is applied. The pulse-train level for a timebase position is registered at the tick that enters that position. It is therefore due one system clock after that edge and lasts 2^(div+1) clocks. The bench keeps a position model advanced at the same edges from the values driven one step after each rising edge. It samples every pin at the falling edge. The directed frame counts start from the first clock of cycle 0, step 0 and cover exactly 256 PWM clocks. A new code is counted only from the second frame start after it is written.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

    typedef enum logic {
        CH_LOW  = 1'b0,
        CH_HIGH = 1'b1
    } ch_state_e;

    // Rate-multiplier slot decode: the lowest set bit of the frame index
    // picks which weight bit owns that cycle (index 0 is never used).
    function automatic logic brm_hit(input logic [7:0] frame,
                                     input logic [7:0] weights,
                                     input int         fb);
        logic found;
        int   tz;
        found = 1'b0;
        tz    = 0;
        for (int k = 0; k < 8; k++) begin
            if (k < fb && !found && frame[k]) begin
                found = 1'b1;
                tz    = k;
            end
        end
        return found ? weights[fb - 1 - tz] : 1'b0;
    endfunction

endpackage

// File: rtl/pwm_dac_regs.sv
module pwm_dac_regs #(
    parameter int NCH      = 5,
    parameter int DW       = 8,
    parameter int AW       = 3,
    parameter int DIV_BITS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [DW-1:0]           rd_data,
    output logic [NCH-1:0][DW-1:0]  data_o,
    output logic [NCH-1:0]          en_o,
    output logic [DIV_BITS-1:0]     div_o
);
    localparam int ADDR_EN  = NCH;
    localparam int ADDR_DIV = NCH + 1;

    logic [NCH-1:0][DW-1:0] data_q;
    logic [NCH-1:0]         en_q;
    logic [DIV_BITS-1:0]    div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            en_q   <= '0;
            div_q  <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == AW'(i)) data_q[i] <= wr_data;
            end
            if (wr_addr == AW'(ADDR_EN))  en_q  <= wr_data[NCH-1:0];
            if (wr_addr == AW'(ADDR_DIV)) div_q <= wr_data[DIV_BITS-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == AW'(i)) rd_data = data_q[i];
        end
        if (rd_addr == AW'(ADDR_EN))  rd_data[NCH-1:0]      = en_q;
        if (rd_addr == AW'(ADDR_DIV)) rd_data[DIV_BITS-1:0] = div_q;
    end

    assign data_o = data_q;
    assign en_o   = en_q;
    assign div_o  = div_q;

    // R9: unmapped writes leave every register untouched
    p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr > AW'(ADDR_DIV))) |=>
            ($stable(data_q) && $stable(en_q) && $stable(div_q)));

endmodule

// File: rtl/pwm_dac_timebase.sv
module pwm_dac_timebase #(
    parameter int BB       = 5,
    parameter int FB       = 3,
    parameter int DIV_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_BITS-1:0] div_i,
    output logic                tick_o,
    output logic                wrap_o,
    output logic [BB-1:0]       base_n_o,
    output logic [FB-1:0]       frame_n_o
);
    localparam int PRE_W = 1 << DIV_BITS;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   lim_w;
    logic [BB-1:0]    base_q;
    logic [FB-1:0]    frame_q;
    logic             base_end;

    always_comb begin
        lim_w     = ((PRE_W + 1)'(1) << (32'(div_i) + 1)) - (PRE_W + 1)'(1);
        tick_o    = ({1'b0, pre_q} >= lim_w);
        base_end  = (base_q == '1);
        wrap_o    = tick_o && base_end && (frame_q == '1);
        base_n_o  = tick_o ? base_q + BB'(1) : base_q;
        frame_n_o = (tick_o && base_end) ? frame_q + FB'(1) : frame_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q   <= '0;
            base_q  <= '0;
            frame_q <= '0;
        end else begin
            pre_q   <= tick_o ? '0 : pre_q + PRE_W'(1);
            base_q  <= base_n_o;
            frame_q <= frame_n_o;
        end
    end

    // R3: ratio is at least two, so ticks never come back to back
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R3: the position only moves on a tick
    p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |=> ($stable(base_q) && $stable(frame_q)));

    // R5: the frame index steps once per completed base cycle
    p_frame_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && base_end) |=> ((frame_q == $past(frame_q) + FB'(1)) && (base_q == '0)));

endmodule

// File: rtl/pwm_dac_channel.sv
module pwm_dac_channel
    import pwm_dac_pkg::*;
#(
    parameter int BB = 5,
    parameter int FB = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wrap_i,
    input  logic [BB-1:0] base_n_i,
    input  logic [FB-1:0] frame_n_i,
    input  logic [DW-1:0] code_i,
    output logic          pwm_o
);
    logic [DW-1:0] act_q;
    logic [DW-1:0] code_sel;
    logic [BB:0]   width_w;
    logic          extra_w;
    logic          high_n;
    ch_state_e     st_q, st_d;

    always_comb begin
        code_sel = wrap_i ? code_i : act_q;
        extra_w  = brm_hit(8'(frame_n_i), 8'(code_sel[FB-1:0]), FB);
        width_w  = {1'b0, code_sel[DW-1:FB]} + (BB + 1)'(extra_w);
        high_n   = ({1'b0, base_n_i} < width_w);
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_LOW:  if (tick_i && high_n)  st_d = CH_HIGH;
            CH_HIGH: if (tick_i && !high_n) st_d = CH_LOW;
            default: st_d = CH_LOW;
        endcase
    end

    // state register and frame-aligned code copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CH_LOW;
            act_q <= '0;
        end else begin
            st_q <= st_d;
            if (wrap_i) act_q <= code_i;
        end
    end

    // output decode
    always_comb begin
        unique case (st_q)
            CH_HIGH: pwm_o = 1'b1;
            default: pwm_o = 1'b0;
        endcase
    end

    // R7: the code in use only changes at a frame wrap
    p_code_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(act_q));

    // R8: a zero code never drives high
    p_zero_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == '0) |-> (st_q == CH_LOW));

    // R4: the level holds between ticks
    p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q));

endmodule

// File: rtl/pwm_dac_top.sv
module pwm_dac_top #(
    parameter int NCH      = 5,
    parameter int DW       = 8,
    parameter int AW       = 3,
    parameter int BB       = 5,
    parameter int FB       = 3,
    parameter int DIV_BITS = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data,
    input  logic [NCH-1:0] port_val,
    output logic [NCH-1:0] pin_out
);
    logic [NCH-1:0][DW-1:0] code_w;
    logic [NCH-1:0]         en_w;
    logic [DIV_BITS-1:0]    div_w;
    logic                   tick_w;
    logic                   wrap_w;
    logic [BB-1:0]          base_n_w;
    logic [FB-1:0]          frame_n_w;
    logic [NCH-1:0]         pwm_w;

    pwm_dac_regs #(.NCH(NCH), .DW(DW), .AW(AW), .DIV_BITS(DIV_BITS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .data_o  (code_w),
        .en_o    (en_w),
        .div_o   (div_w)
    );

    pwm_dac_timebase #(.BB(BB), .FB(FB), .DIV_BITS(DIV_BITS)) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_i     (div_w),
        .tick_o    (tick_w),
        .wrap_o    (wrap_w),
        .base_n_o  (base_n_w),
        .frame_n_o (frame_n_w)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_dac_channel #(.BB(BB), .FB(FB), .DW(DW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick_w),
            .wrap_i    (wrap_w),
            .base_n_i  (base_n_w),
            .frame_n_i (frame_n_w),
            .code_i    (code_w[g]),
            .pwm_o     (pwm_w[g])
        );
    end

    assign pin_out = (pwm_w & en_w) | (port_val & ~en_w);

    // R6: disabled pins follow the general-purpose value
    p_gpio_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_out ^ port_val) & ~en_w) == '0));

endmodule

// File: tb/test_pwm_dac_top.sv
module test_pwm_dac_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [4:0] port_val = '0;
    logic [4:0] pin_out;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    chk_on = 1'b0;
    string cur_tag = "R4";

    // reference timebase and registers
    int m_pre, m_base, m_frame, m_div;
    int m_data [NCH];
    int m_act  [NCH];
    int m_en;

    pwm_dac_top i_pwm_dac_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .port_val(port_val), .pin_out(pin_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int slot_ref(int f, int code);
        int w;
        w = code & 7;
        if (f == 4) return w & 1;
        if (f == 2 || f == 6) return (w >> 1) & 1;
        if (f % 2 == 1) return (w >> 2) & 1;
        return 0;
    endfunction

    function automatic bit lvl_ref(int code, int b, int f);
        return b < ((code >> 3) + slot_ref(f, code));
    endfunction

    function automatic int frame_highs(int code);
        return 8 * (code >> 3) + (code & 7);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre <= 0; m_base <= 0; m_frame <= 0; m_div <= 0; m_en <= 0;
            for (int i = 0; i < NCH; i++) begin
                m_data[i] <= 0; m_act[i] <= 0;
            end
        end else begin
            if (wr_en) begin
                if (wr_addr < 5) m_data[wr_addr] <= wr_data;
                if (wr_addr == 5) m_en <= wr_data & 8'h1F;
                if (wr_addr == 6) m_div <= wr_data & 8'h03;
            end
            if (m_pre >= (1 << (m_div + 1)) - 1) begin
                m_pre <= 0;
                if (m_base == 31) begin
                    m_base <= 0;
                    if (m_frame == 7) begin
                        m_frame <= 0;
                        for (int i = 0; i < NCH; i++) m_act[i] <= m_data[i];
                    end else m_frame <= m_frame + 1;
                end else m_base <= m_base + 1;
            end else m_pre <= m_pre + 1;
        end
    end

    task automatic check(string tag, bit ok, int act, int exp, string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // continuous pin check at the falling edge
    always @(negedge clk) begin
        if (chk_on) begin
            for (int i = 0; i < NCH; i++) begin
                bit e;
                e = m_en[i] ? lvl_ref(m_act[i], m_base, m_frame) : port_val[i];
                check(cur_tag, pin_out[i] == e, pin_out[i], e, $sformatf("pin %0d", i));
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(int a, int d);
        step();
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_check(string tag, int a, int exp);
        step();
        rd_addr = 3'(a);
        @(negedge clk);
        check(tag, rd_data == 8'(exp), rd_data, exp, $sformatf("readback addr %0d", a));
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (!(m_base == 0 && m_frame == 0 && m_pre == 0));
    endtask

    // counts high samples of one pin over one frame from the current frame start
    task automatic count_frame(int ch, output int highs);
        int r;
        r = 1 << (m_div + 1);
        highs = 0;
        for (int k = 0; k < 256 * r; k++) begin
            if (k > 0) @(negedge clk);
            highs += pin_out[ch];
        end
        highs = highs / r;
    endtask

    initial begin
        int h;
        void'($urandom(32'd2468));
        port_val = 5'b10110;
        repeat (3) step();
        @(negedge clk);
        for (int i = 0; i < NCH; i++)
            check("R2", pin_out[i] == port_val[i], pin_out[i], port_val[i], "pin in reset");
        step(); rst_n = 1'b1;

        for (int a = 0; a < 7; a++) rd_check("R2", a, 0);
        port_val = 5'b01011;
        @(negedge clk);
        check("R2", pin_out == port_val, pin_out, port_val, "gpio pass after reset");

        wr(7, 8'hFF);
        for (int a = 0; a < 7; a++) rd_check("R9", a, 0);
        @(negedge clk);
        check("R9", pin_out == port_val, pin_out, port_val, "pins after unmapped write");

        for (int a = 0; a < 5; a++) begin
            int v;
            v = $urandom_range(255);
            wr(a, v);
            rd_check("R1", a, v);
        end
        wr(5, 8'hFF); rd_check("R1", 5, 8'h1F);
        wr(6, 8'hFE); rd_check("R1", 6, 8'h02);
        wr(6, 0);

        chk_on = 1'b1;
        for (int it = 0; it < 40; it++) begin
            cur_tag = (it % 3 == 0) ? "R4" : ((it % 3 == 1) ? "R5" : "R6");
            case ($urandom_range(3))
                0: wr($urandom_range(4), $urandom_range(255));
                1: wr(5, $urandom_range(31));
                2: wr(6, $urandom_range(3));
                default: begin
                    step(); port_val = 5'($urandom_range(31));
                end
            endcase
            repeat ($urandom_range(50, 800)) step();
        end

        // directed frame totals, divide ratio 2
        cur_tag = "R5";
        wr(6, 0); wr(5, 8'h1F);
        wr(0, 8'h83); wr(1, 8'hFF); wr(2, 8'h07); wr(3, 8'h00); wr(4, 8'hFF);
        wait_frame(); step(); wait_frame();
        fork
            begin count_frame(0, h); check("R5", h == frame_highs(8'h83), h, frame_highs(8'h83), "frame highs 83h"); end
            begin int h1; count_frame(1, h1); check("R5", h1 == frame_highs(8'hFF), h1, frame_highs(8'hFF), "frame highs FFh"); end
            begin int h2; count_frame(2, h2); check("R5", h2 == 7, h2, 7, "frame highs 07h"); end
            begin int h3; count_frame(3, h3); check("R8", h3 == 0, h3, 0, "frame highs 00h"); end
            begin
                for (int k = 0; k < 512; k++) begin
                    @(negedge clk);
                    check("R10", pin_out[4] == pin_out[1], pin_out[4], pin_out[1], "equal codes");
                end
            end
        join

        // mid-frame code change
        cur_tag = "R7";
        wr(0, 8'h80);
        wait_frame(); step(); wait_frame();
        fork
            begin count_frame(0, h); end
            begin repeat (20) step(); wr(0, 8'h08); end
        join
        check("R7", h == 128, h, 128, "frame of mid-frame write");
        wait_frame();
        count_frame(0, h);
        check("R7", h == 8, h, 8, "frame after write");

        // PWM clock length per divider setting: code 08h is one PWM clock high
        cur_tag = "R3";
        for (int d = 0; d < 4; d++) begin
            int run;
            wr(6, d);
            wait_frame(); step(); wait_frame();
            run = 0;
            while (pin_out[0] == 1'b1) begin
                run++;
                @(negedge clk);
            end
            check("R3", run == (1 << (d + 1)), run, 1 << (d + 1), $sformatf("high run div %0d", d));
        end

        chk_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=%0d expected=150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule